// File: doc/BRIEF.md
# Flash Write Protection Controller

This block sits between the command decoder and the array engine of a small sectored serial flash and decides, one command at a time, whether a program, an erase or a status register update may go ahead. It keeps the write enable latch, the two-bit block protect field and the write-protect-pin enable bit. It turns each decoded command into exactly one outcome pulse: a program grant, an erase grant, a status commit, or a denial.

Block protection works on the address alone. Depending on the protect field, it covers nothing, the top quarter of the array, the top half, or all of it. A status register write is first held as pending while chip select stays low. The write becomes final only when chip select rises, which is where the internal write cycle starts. Until then, a falling write protect pin cancels it if the pin enable bit is set. Once the cycle has started, the pin has no further effect on that write. The array programming, the self-timed cycle and the serial shifter are outside this block. The engine reports the end of a granted program or erase on `op_done_i`.

Top module: `wpc_top`

## Requirements
- R1: After reset the write enable latch, the protect field, the pin enable bit and the pending flag are all 0, and no outcome pulse is raised.
- R2: Command codes are 1 = write enable, 2 = write disable, 3 = program, 4 = erase, 5 = status write; codes 0, 6 and 7 change nothing. Write enable sets the latch and write disable clears it, both visible on `wel_o` one cycle after the command.
- R3: A program, erase or status write issued while the latch is 0 raises `deny_o` for one cycle, grants nothing and leaves the status bits unchanged.
- R4: Protect field encoding: 00 protects nothing, 01 protects addresses whose two top bits are 11, 10 protects addresses whose top bit is 1, 11 protects every address. A program or erase to a protected address is denied.
- R5: A program or erase to an unprotected address with the latch set raises `prog_go_o` or `erase_go_o` for one cycle after the command. The latch stays set until `op_done_i` is pulsed, and it reads 0 in the cycle after that pulse.
- R6: Every denial clears the write enable latch.
- R7: With the pin enable bit at 1 and `wp_n_i` low, a status write is denied and never becomes pending.
- R8: With the pin enable bit at 0, `wp_n_i` is ignored, and a status write with the latch set becomes pending even while the pin is low.
- R9: While a status write is pending and `cs_n_i` is still low, `wp_n_i` low with the pin enable bit at 1 cancels it. This raises `deny_o`, clears the latch and leaves the status bits unchanged.
- R10: A pending status write commits when `cs_n_i` is high. One cycle later the new protect field and pin enable bit appear, `sr_go_o` pulses and the latch reads 0. A later fall of `wp_n_i` does not change the committed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Decoded command present this cycle |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W | Target byte address of program or erase |
| sr_bp_i | input | 2 | Protect field carried by a status write |
| sr_wpen_i | input | 1 | Pin enable bit carried by a status write |
| wp_n_i | input | 1 | Write protect pin, active low |
| cs_n_i | input | 1 | Chip select, active low |
| op_done_i | input | 1 | Granted program or erase finished |
| prog_go_o | output | 1 | Program granted (one cycle pulse) |
| erase_go_o | output | 1 | Erase granted (one cycle pulse) |
| sr_go_o | output | 1 | Status write committed (one cycle pulse) |
| deny_o | output | 1 | Command refused or status write cancelled |
| wel_o | output | 1 | Write enable latch |
| bp_o | output | 2 | Current protect field |
| wpen_o | output | 1 | Current write-protect-pin enable bit |
| sr_pend_o | output | 1 | Status write accepted, cycle not yet started |

## Verification
The hardest case is the window between accepting a status write and the rise of chip select. Only there does a write protect fall matter. Hitting it needs a committed pin enable bit of 1 first, and that takes an earlier full status write with the latch set, made with the pin high or with the bit still 0. The stimulus therefore chains status writes. It first commits a write with the pin held low while the enable bit is 0. It then leaves a later write pending with chip select low and drops the pin. Finally it repeats the write, lets chip select rise and drops the pin after the commit.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int unsigned CMD_W = 3;
  localparam int unsigned BP_W  = 2;

  typedef enum logic [CMD_W-1:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_PROG  = 3'd3,
    OP_ERASE = 3'd4,
    OP_WRSR  = 3'd5
  } op_e;

  typedef enum logic [BP_W-1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;

  typedef struct packed {
    logic [BP_W-1:0] bp;
    logic            wpen;
  } sreg_t;
endpackage

// File: rtl/wpc_region_guard.sv
module wpc_region_guard #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [wpc_pkg::BP_W-1:0] bp_i,
  output logic                     hit_o
);
  import wpc_pkg::*;

  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (prot_e'(bp_i))
      PROT_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
      PROT_HALF:    hit_o = addr_i[TOP];
      PROT_ALL:     hit_o = 1'b1;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wpc_wel_latch.sv
module wpc_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_d, wel_q;

  always_comb begin
    wel_d = wel_q;
    if (set_i) wel_d = 1'b1;
    if (clr_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  assign wel_o = wel_q;

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> wel_o);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wel_o);
endmodule

// File: rtl/wpc_sr_seq.sv
module wpc_sr_seq (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept_i,
  input  logic [wpc_pkg::BP_W-1:0] new_bp_i,
  input  logic                     new_wpen_i,
  input  logic                     cs_n_i,
  input  logic                     wp_n_i,
  output logic                     pend_o,
  output logic                     commit_now_o,
  output logic                     abort_now_o,
  output logic [wpc_pkg::BP_W-1:0] bp_o,
  output logic                     wpen_o
);
  import wpc_pkg::*;

  sreg_t sr_d, sr_q, hold_d, hold_q;
  logic  pend_d, pend_q;

  always_comb begin
    pend_d       = pend_q;
    sr_d         = sr_q;
    hold_d       = hold_q;
    commit_now_o = 1'b0;
    abort_now_o  = 1'b0;
    if (pend_q) begin
      if (cs_n_i) begin
        commit_now_o = 1'b1;
        sr_d         = hold_q;
        pend_d       = 1'b0;
      end else if (sr_q.wpen && !wp_n_i) begin
        abort_now_o = 1'b1;
        pend_d      = 1'b0;
      end
    end else if (accept_i) begin
      pend_d = 1'b1;
      hold_d = '{bp: new_bp_i, wpen: new_wpen_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      pend_q <= pend_d;
      sr_q   <= sr_d;
      hold_q <= hold_d;
    end
  end

  assign pend_o = pend_q;
  assign bp_o   = sr_q.bp;
  assign wpen_o = sr_q.wpen;

  assert_idle_holds_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o |=> $stable(sr_q));
  assert_abort_keeps_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !cs_n_i && wpen_o && !wp_n_i) |=> (!pend_o && $stable(sr_q)));
endmodule

// File: rtl/wpc_top.sv
module wpc_top #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  input  logic [wpc_pkg::CMD_W-1:0] cmd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [wpc_pkg::BP_W-1:0] sr_bp_i,
  input  logic                     sr_wpen_i,
  input  logic                     wp_n_i,
  input  logic                     cs_n_i,
  input  logic                     op_done_i,
  output logic                     prog_go_o,
  output logic                     erase_go_o,
  output logic                     sr_go_o,
  output logic                     deny_o,
  output logic                     wel_o,
  output logic [wpc_pkg::BP_W-1:0] bp_o,
  output logic                     wpen_o,
  output logic                     sr_pend_o
);
  import wpc_pkg::*;

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_l = rst_pipe_q[SYNC_N-1];

  logic is_wren, is_wrdi, is_prog, is_erase, is_wrsr;
  logic hit, pin_lock, wel;
  logic prog_ok, erase_ok, sr_accept, refuse, deny_d;
  logic commit_now, abort_now, pend;
  logic prog_q, erase_q, sr_go_q, deny_q;

  always_comb begin
    is_wren  = cmd_valid_i && (cmd_i == OP_WREN);
    is_wrdi  = cmd_valid_i && (cmd_i == OP_WRDI);
    is_prog  = cmd_valid_i && (cmd_i == OP_PROG);
    is_erase = cmd_valid_i && (cmd_i == OP_ERASE);
    is_wrsr  = cmd_valid_i && (cmd_i == OP_WRSR);
  end

  wpc_region_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr_i (addr_i),
    .bp_i   (bp_o),
    .hit_o  (hit)
  );

  always_comb begin
    pin_lock  = wpen_o && !wp_n_i;
    prog_ok   = is_prog  && wel && !hit;
    erase_ok  = is_erase && wel && !hit;
    sr_accept = is_wrsr  && wel && !pin_lock && !pend;
    refuse    = (is_prog || is_erase || is_wrsr) && !(prog_ok || erase_ok || sr_accept);
    deny_d    = refuse || abort_now;
  end

  wpc_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_l),
    .set_i (is_wren),
    .clr_i (is_wrdi || deny_d || commit_now || op_done_i),
    .wel_o (wel)
  );

  wpc_sr_seq u_sr (
    .clk          (clk),
    .rst_n        (rst_l),
    .accept_i     (sr_accept),
    .new_bp_i     (sr_bp_i),
    .new_wpen_i   (sr_wpen_i),
    .cs_n_i       (cs_n_i),
    .wp_n_i       (wp_n_i),
    .pend_o       (pend),
    .commit_now_o (commit_now),
    .abort_now_o  (abort_now),
    .bp_o         (bp_o),
    .wpen_o       (wpen_o)
  );

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      sr_go_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      prog_q  <= prog_ok;
      erase_q <= erase_ok;
      sr_go_q <= commit_now;
      deny_q  <= deny_d;
    end
  end

  assign prog_go_o  = prog_q;
  assign erase_go_o = erase_q;
  assign sr_go_o    = sr_go_q;
  assign deny_o     = deny_q;
  assign wel_o      = wel;
  assign sr_pend_o  = pend;

  assert_no_prog_without_wel_R3: assert property (@(posedge clk) disable iff (!rst_l)
    (is_prog && !wel_o) |=> (!prog_go_o && deny_o));
  assert_protected_denied_R4: assert property (@(posedge clk) disable iff (!rst_l)
    ((is_prog || is_erase) && hit) |=> (!prog_go_o && !erase_go_o && deny_o));
  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_l)
    $onehot0({prog_go_o, erase_go_o, sr_go_o, deny_o}));
  assert_pin_lock_R7: assert property (@(posedge clk) disable iff (!rst_l)
    (is_wrsr && !sr_pend_o && wpen_o && !wp_n_i) |=> (!sr_pend_o && deny_o));
  assert_commit_clears_wel_R10: assert property (@(posedge clk) disable iff (!rst_l)
    sr_go_o |-> !wel_o);
endmodule

// File: tb/test_wpc_top.sv
`timescale 1ns/1ps
module test_wpc_top;
  localparam int unsigned AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd;
  logic [AW-1:0] addr;
  logic [1:0]    sbp;
  logic          swpen, wp_n, cs_n, done;
  logic          prog_go, erase_go, sr_go, deny, wel, wpen, pend;
  logic [1:0]    bp;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] pulses;
    logic       wel;
    logic [1:0] bp;
    logic       wpen;
    logic       pend;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  wpc_top #(.ADDR_W(AW)) i_wpc_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(addr),
    .sr_bp_i(sbp), .sr_wpen_i(swpen), .wp_n_i(wp_n), .cs_n_i(cs_n), .op_done_i(done),
    .prog_go_o(prog_go), .erase_go_o(erase_go), .sr_go_o(sr_go), .deny_o(deny),
    .wel_o(wel), .bp_o(bp), .wpen_o(wpen), .sr_pend_o(pend)
  );

  task automatic compare(input exp_t e);
    logic [3:0] p;
    p = {prog_go, erase_go, sr_go, deny};
    checks++;
    if (p !== e.pulses || wel !== e.wel || bp !== e.bp || wpen !== e.wpen || pend !== e.pend) begin
      errors++;
      $display("FAIL %s: got pulses=%b wel=%b bp=%b wpen=%b pend=%b, expected pulses=%b wel=%b bp=%b wpen=%b pend=%b",
               e.tag, p, wel, bp, wpen, pend, e.pulses, e.wel, e.bp, e.wpen, e.pend);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) compare(sb_q.pop_front());
  end

  task automatic step(input logic [2:0] c, input logic [AW-1:0] a, input logic wp, input logic cs,
                      input logic dn, input logic [1:0] dbp, input logic dwp,
                      input logic [3:0] ep, input logic ew, input logic [1:0] eb,
                      input logic ewp, input logic epd, input string t);
    exp_t e;
    @(negedge clk);
    cmd = c; addr = a; wp_n = wp; cs_n = cs; done = dn; sbp = dbp; swpen = dwp;
    e.pulses = ep; e.wel = ew; e.bp = eb; e.wpen = ewp; e.pend = epd; e.tag = t;
    sb_q.push_back(e);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    exp_t r;
    rst_n = 1'b0; cmd_valid = 1'b1; cmd = 3'd0; addr = '0; sbp = 2'b00; swpen = 1'b0;
    wp_n = 1'b1; cs_n = 1'b0; done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.pulses = 4'b0000; r.wel = 1'b0; r.bp = 2'b00; r.wpen = 1'b0; r.pend = 1'b0; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // pulses order: {prog, erase, sr, deny}
    step(3'd0, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 0, 2'b00, 0, 0, "R1 idle after reset");
    step(3'd3, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b00, 0, 0, "R3 program without latch");
    step(3'd5, 17'h00000, 1, 0, 0, 2'b11, 1, 4'b0001, 0, 2'b00, 0, 0, "R3 status write without latch");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 write enable");
    step(3'd2, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 0, 2'b00, 0, 0, "R2 write disable");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 write enable again");
    step(3'd3, 17'h00100, 1, 0, 0, 2'b00, 0, 4'b1000, 1, 2'b00, 0, 0, "R5 program granted");
    step(3'd0, 17'h00000, 1, 0, 1, 2'b00, 0, 4'b0000, 0, 2'b00, 0, 0, "R5 done clears latch");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 enable");
    step(3'd4, 17'h10000, 1, 0, 0, 2'b00, 0, 4'b0100, 1, 2'b00, 0, 0, "R5 erase granted");
    step(3'd0, 17'h00000, 1, 0, 1, 2'b00, 0, 4'b0000, 0, 2'b00, 0, 0, "R5 erase done");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 enable");
    step(3'd5, 17'h00000, 1, 0, 0, 2'b01, 0, 4'b0000, 1, 2'b00, 0, 1, "R8 status write pending");
    step(3'd0, 17'h00000, 1, 1, 0, 2'b00, 0, 4'b0010, 0, 2'b01, 0, 0, "R10 commit quarter");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b01, 0, 0, "R2 enable");
    step(3'd3, 17'h18000, 1, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b01, 0, 0, "R4 R6 top quarter denied");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b01, 0, 0, "R2 enable");
    step(3'd3, 17'h10000, 1, 0, 0, 2'b00, 0, 4'b1000, 1, 2'b01, 0, 0, "R4 below quarter granted");
    step(3'd0, 17'h00000, 1, 0, 1, 2'b00, 0, 4'b0000, 0, 2'b01, 0, 0, "R5 done");
    step(3'd1, 17'h00000, 0, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b01, 0, 0, "R2 enable with pin low");
    step(3'd5, 17'h00000, 0, 0, 0, 2'b10, 1, 4'b0000, 1, 2'b01, 0, 1, "R8 pin ignored while enable bit 0");
    step(3'd0, 17'h00000, 0, 1, 0, 2'b00, 0, 4'b0010, 0, 2'b10, 1, 0, "R8 R10 commit half with pin low");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b10, 1, 0, "R2 enable");
    step(3'd4, 17'h10000, 1, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b10, 1, 0, "R4 R6 top half erase denied");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b10, 1, 0, "R2 enable");
    step(3'd4, 17'h0F000, 1, 0, 0, 2'b00, 0, 4'b0100, 1, 2'b10, 1, 0, "R4 lower half erase granted");
    step(3'd0, 17'h00000, 1, 0, 1, 2'b00, 0, 4'b0000, 0, 2'b10, 1, 0, "R5 done");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b10, 1, 0, "R2 enable");
    step(3'd5, 17'h00000, 0, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b10, 1, 0, "R7 pin lock refuses status write");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b10, 1, 0, "R2 enable");
    step(3'd5, 17'h00000, 1, 0, 0, 2'b11, 1, 4'b0000, 1, 2'b10, 1, 1, "R9 status write pending");
    step(3'd0, 17'h00000, 0, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b10, 1, 0, "R9 pin fall cancels");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b10, 1, 0, "R2 enable");
    step(3'd5, 17'h00000, 1, 0, 0, 2'b11, 1, 4'b0000, 1, 2'b10, 1, 1, "R10 status write pending");
    step(3'd0, 17'h00000, 1, 1, 0, 2'b00, 0, 4'b0010, 0, 2'b11, 1, 0, "R10 commit all");
    step(3'd0, 17'h00000, 0, 1, 0, 2'b00, 0, 4'b0000, 0, 2'b11, 1, 0, "R10 late pin fall no effect");
    step(3'd0, 17'h00000, 0, 0, 0, 2'b00, 0, 4'b0000, 0, 2'b11, 1, 0, "R10 bits still held");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b11, 1, 0, "R2 enable");
    step(3'd3, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0001, 0, 2'b11, 1, 0, "R4 whole array denied");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b11, 1, 0, "R2 enable");
    step(3'd5, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b11, 1, 1, "R10 clearing write pending");
    step(3'd0, 17'h00000, 1, 1, 0, 2'b00, 0, 4'b0010, 0, 2'b00, 0, 0, "R10 commit none");
    step(3'd1, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 enable");
    step(3'd7, 17'h00000, 1, 0, 0, 2'b11, 1, 4'b0000, 1, 2'b00, 0, 0, "R2 unused code ignored");
    step(3'd6, 17'h00000, 1, 0, 0, 2'b11, 1, 4'b0000, 1, 2'b00, 0, 0, "R2 unused code six ignored");
    step(3'd0, 17'h00000, 1, 0, 0, 2'b00, 0, 4'b0000, 1, 2'b00, 0, 0, "R2 latch still set");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule